// File: doc/BRIEF.md
# Byte-Masked Scratch RAM with Access Trace

This block is a small word-organised scratch memory with one read command port and one write command port that can both fire in the same cycle. Each word is 32 bits wide. The capacity in bytes is a parameter, and both ports take byte addresses. A write carries a 4-bit lane mask, and only the enabled bytes of the addressed word change. A read returns the whole word one clock after the command.

Every accepted access also produces one trace record on a separate output. The record carries a subsystem code, an access kind, four 64-bit argument fields and a 32-bit flags field. The arguments hold the byte address, the data, the lane mask and a tag word. The tag word combines a fixed region code with the requester identifier that was presented alongside the command. The trace output can show only one record per cycle. When both ports fire together, the write record goes out first, and the read record goes out on the following cycle. A small internal queue holds any records that are waiting. A downstream collector consumes the records, and the block itself does not arbitrate between requesters.

Top module: `bemem_trace_ram`

## Requirements
- R1: After reset, a word that has not yet been written reads as 0x00000000. At reset, rd_valid and evt_valid are low and rd_data is zero.
- R2: A write changes byte lane i (bits 8i+7..8i) of the addressed word only when wr_be[i] is 1. The other lanes keep their previous value.
- R3: rd_valid is high in exactly the cycle after each cycle in which rd_en was high, and it is low otherwise. In that cycle, rd_data holds the word that was read.
- R4: Address bits [1:0] are ignored for storage, and the word is selected by address[ADDR_W-1:2]. A write to one word leaves every other word unchanged.
- R5: Every accepted access yields exactly one record with evt_valid high for one cycle. evt_kind is 0 for a read and 1 for a write, and evt_subsys is always 2.
- R6: evt_arg3 equals {48'b0, req_master, 8'd2}, which puts the region code 2 in bits [7:0] and the requester in bits [15:8]. evt_flags is zero.
- R7: evt_arg0 is the full byte address, zero-extended. evt_arg1 is the data: the unmasked write data for a write, or the returned word for a read. evt_arg2 is the lane mask, and it is 0xF for a read.
- R8: With no records waiting, a lone access produces its record in the cycle after the command, and a read record lines up with rd_valid. A read and a write in the same cycle give the write record first and the read record one cycle later.
- R9: A read and a write to the same word in the same cycle return the word as it was before the write.
- R10: Waiting records leave in arrival order. The queue never holds more than EVQ_DEPTH records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read command |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | rd_data valid, one cycle after rd_en |
| wr_en | input | 1 | Write command |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write word |
| wr_be | input | 4 | Byte lane mask for the write |
| req_master | input | 8 | Requester identifier for this cycle's accesses |
| evt_valid | output | 1 | Trace record valid |
| evt_subsys | output | 4 | Subsystem code (2) |
| evt_kind | output | 2 | 0 = read, 1 = write |
| evt_arg0 | output | 64 | Byte address |
| evt_arg1 | output | 64 | Data |
| evt_arg2 | output | 64 | Lane mask |
| evt_arg3 | output | 64 | {requester, region code} |
| evt_flags | output | 32 | Always zero |

## Verification
The bench uses a 16-word configuration and first reads every word straight after reset. It then writes each word with all sixteen lane masks. Each write carries a different data value and requester, and uses a different low address offset from the read-back that follows, so lane-merging faults and low-bit indexing faults show up separately. A full read sweep afterwards shows whether a write leaked into a neighbouring word. Collisions on the same word and on different words, including two collisions in a row, separate old-data-on-collision from forwarding. They also show whether the write-first ordering and the queue drain are correct.

// File: rtl/bemem_pkg.sv
// Shared constants and the trace record type for the byte-masked trace RAM.
// Assumes 32-bit words with four byte lanes.
package bemem_pkg;
    localparam int WORD_W   = 32;
    localparam int LANES    = 4;
    localparam int MID_W    = 8;
    localparam int ARG_W    = 64;
    localparam int SUBSYS_W = 4;
    localparam int FLAG_W   = 32;

    localparam logic [SUBSYS_W-1:0] SUBSYS_IOPROC = 4'd2;
    localparam logic [7:0]          REGION_LOCAL  = 8'd2;

    typedef enum logic [1:0] {
        EVK_READ  = 2'd0,
        EVK_WRITE = 2'd1
    } evkind_e;

    // One pending trace record; the address is held zero-extended to 32 bits.
    typedef struct packed {
        evkind_e             kind;
        logic [31:0]         addr;
        logic [WORD_W-1:0]   data;
        logic [LANES-1:0]    mask;
        logic [MID_W-1:0]    master;
    } evrec_t;
endpackage

// File: rtl/bemem_merge.sv
// Byte-lane merge: each output lane takes the new byte when its mask bit is
// set, otherwise the base byte. Purely combinational.
module bemem_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] base,
    input  logic [LANES*8-1:0] wdata,
    input  logic [LANES-1:0]   be,
    output logic [LANES*8-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Select one byte lane
        assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : base[g*8 +: 8];
    end
endmodule

// File: rtl/bemem_store.sv
// Word storage with a per-word "written" flag so that unwritten words read
// as zero without clearing the array at reset. Reads are registered (one
// cycle); the combinational pre-write word is also exported for tracing.
// Assumes SIZE_BYTES is a power of two and at least 8.
module bemem_store
    import bemem_pkg::*;
#(
    parameter int SIZE_BYTES = 4096,
    localparam int ADDR_W = $clog2(SIZE_BYTES),
    localparam int IDX_W  = ADDR_W - 2,
    localparam int WORDS  = SIZE_BYTES / LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic [WORD_W-1:0] rd_old,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  written;
    logic [WORD_W-1:0] wr_base;
    logic [WORD_W-1:0] wr_merged;

    assign rd_old  = written[rd_idx] ? mem[rd_idx] : '0;
    assign wr_base = written[wr_idx] ? mem[wr_idx] : '0;

    bemem_merge #(.LANES(LANES)) merge_i (
        .base   (wr_base),
        .wdata  (wr_data),
        .be     (wr_be),
        .merged (wr_merged)
    );

    // Store the merged word; the array itself carries no reset
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_merged;
    end

    // Track which words have been written since reset
    always_ff @(posedge clk) begin
        if (!rst_n)     written <= '0;
        else if (wr_en) written[wr_idx] <= 1'b1;
    end

    // Register the read word and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_old;
        end
    end

    // R1: a word never written since reset reads back as zero
    a_r1_unwritten_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !written[rd_idx]) |=> (rd_data == '0));

    // R2: a full-mask write leaves exactly the written word in storage
    a_r2_full_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == '1) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/bemem_evq.sv
// Trace record sequencer: emits one record per cycle, write before read
// within a cycle, holding the surplus in a small ring queue. When the queue
// is empty a new record bypasses it straight to the output register.
// Assumes EVQ_DEPTH is a power of two >= 2 and that the caller's access
// pattern never overfills it.
module bemem_evq
    import bemem_pkg::*;
#(
    parameter int EVQ_DEPTH = 4,
    localparam int PTR_W = $clog2(EVQ_DEPTH),
    localparam int CNT_W = $clog2(EVQ_DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_fire,
    input  evrec_t wr_rec,
    input  logic   rd_fire,
    input  evrec_t rd_rec,
    output logic   ev_valid,
    output evrec_t ev_rec,
    output logic   q_empty
);
    evrec_t           slots [EVQ_DEPTH];
    logic [PTR_W-1:0] rptr, wptr, wptr_nx;
    logic [CNT_W-1:0] count;
    logic [1:0]       n_new, n_push;
    logic             take_head, out_valid;
    evrec_t           out_rec, push_a, push_b;

    assign q_empty = (count == '0);
    assign n_new   = 2'(wr_fire) + 2'(rd_fire);
    assign wptr_nx = wptr + PTR_W'(1);

    // Pick the next record to emit and the records to enqueue
    always_comb begin
        take_head = 1'b0;
        out_rec   = '0;
        push_a    = '0;
        push_b    = '0;
        n_push    = 2'd0;
        if (!q_empty) begin
            take_head = 1'b1;
            out_rec   = slots[rptr];
            push_a    = wr_fire ? wr_rec : rd_rec;
            push_b    = rd_rec;
            n_push    = n_new;
        end else if (wr_fire) begin
            out_rec = wr_rec;
            push_a  = rd_rec;
            n_push  = 2'(rd_fire);
        end else if (rd_fire) begin
            out_rec = rd_rec;
        end
        out_valid = !q_empty || (n_new != 2'd0);
    end

    // Fill queue slots; no reset needed on the payload
    always_ff @(posedge clk) begin
        if (n_push != 2'd0) slots[wptr]    <= push_a;
        if (n_push == 2'd2) slots[wptr_nx] <= push_b;
    end

    // Advance pointers, occupancy and the output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= '0;
            wptr     <= '0;
            count    <= '0;
            ev_valid <= 1'b0;
            ev_rec   <= '0;
        end else begin
            rptr     <= rptr + PTR_W'(take_head);
            wptr     <= wptr + PTR_W'(n_push);
            count    <= count + CNT_W'(n_push) - CNT_W'(take_head);
            ev_valid <= out_valid;
            if (out_valid) ev_rec <= out_rec;
        end
    end

    // R10: the queue never grows past its depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(count) + 32'(n_push) - 32'(take_head)) <= EVQ_DEPTH);

    // R8: with nothing waiting, a same-cycle pair emits the write first
    a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && rd_fire && q_empty) |=> (ev_valid && ev_rec.kind == EVK_WRITE));

    // R8: the deferred read of such a pair follows on the next cycle
    a_r8_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && rd_fire && q_empty) |=> ##1 (ev_valid && ev_rec.kind == EVK_READ));
endmodule

// File: rtl/bemem_trace_ram.sv
// Top: byte-masked scratch RAM whose every access is mirrored as a trace
// record carrying subsystem, kind, address, data, mask and a tag word of
// {requester, region}. Assumes req_master applies to both ports in a cycle.
module bemem_trace_ram
    import bemem_pkg::*;
#(
    parameter int SIZE_BYTES = 4096,
    parameter int EVQ_DEPTH  = 4,
    localparam int ADDR_W = $clog2(SIZE_BYTES),
    localparam int IDX_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    input  logic [7:0]        req_master,
    output logic              evt_valid,
    output logic [3:0]        evt_subsys,
    output logic [1:0]        evt_kind,
    output logic [63:0]       evt_arg0,
    output logic [63:0]       evt_arg1,
    output logic [63:0]       evt_arg2,
    output logic [63:0]       evt_arg3,
    output logic [31:0]       evt_flags
);
    logic [WORD_W-1:0] rd_old;
    evrec_t            wr_rec, rd_rec, q_rec;
    logic              q_empty;

    bemem_store #(.SIZE_BYTES(SIZE_BYTES)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_idx   (rd_addr[ADDR_W-1:2]),
        .wr_en    (wr_en),
        .wr_idx   (wr_addr[ADDR_W-1:2]),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .rd_old   (rd_old),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Form the two candidate records for this cycle
    always_comb begin
        wr_rec        = '0;
        wr_rec.kind   = EVK_WRITE;
        wr_rec.addr   = 32'(wr_addr);
        wr_rec.data   = wr_data;
        wr_rec.mask   = wr_be;
        wr_rec.master = req_master;
        rd_rec        = '0;
        rd_rec.kind   = EVK_READ;
        rd_rec.addr   = 32'(rd_addr);
        rd_rec.data   = rd_old;
        rd_rec.mask   = '1;
        rd_rec.master = req_master;
    end

    bemem_evq #(.EVQ_DEPTH(EVQ_DEPTH)) evq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_en),
        .wr_rec   (wr_rec),
        .rd_fire  (rd_en),
        .rd_rec   (rd_rec),
        .ev_valid (evt_valid),
        .ev_rec   (q_rec),
        .q_empty  (q_empty)
    );

    // Expand the held record into the wide trace fields
    assign evt_subsys = evt_valid ? SUBSYS_IOPROC : '0;
    assign evt_kind   = q_rec.kind;
    assign evt_arg0   = ARG_W'(q_rec.addr);
    assign evt_arg1   = ARG_W'(q_rec.data);
    assign evt_arg2   = ARG_W'(q_rec.mask);
    assign evt_arg3   = {48'b0, q_rec.master, REGION_LOCAL};
    assign evt_flags  = '0;

    // R8: a lone read with nothing waiting lines its record up with rd_valid
    a_r8_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && q_empty) |=> (evt_valid && evt_kind == EVK_READ && rd_valid));

    // R5: a lone write with nothing waiting is traced on the next cycle
    a_r5_write_traced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && q_empty) |=> (evt_valid && evt_kind == EVK_WRITE && !rd_valid));
endmodule

// File: tb/bemem_trace_ram_tb_top.sv
module bemem_trace_ram_tb_top;
    localparam int SZ    = 64;
    localparam int AW    = $clog2(SZ);
    localparam int NW    = SZ / 4;
    localparam int EQMAX = 1024;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_en, wr_en, rd_valid, evt_valid;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0]   rd_data, wr_data, evt_flags;
    logic [3:0]    wr_be, evt_subsys;
    logic [7:0]    req_master;
    logic [1:0]    evt_kind;
    logic [63:0]   evt_arg0, evt_arg1, evt_arg2, evt_arg3;

    always #5 clk = ~clk;

    bemem_trace_ram #(.SIZE_BYTES(SZ), .EVQ_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .req_master(req_master),
        .evt_valid(evt_valid), .evt_subsys(evt_subsys), .evt_kind(evt_kind),
        .evt_arg0(evt_arg0), .evt_arg1(evt_arg1), .evt_arg2(evt_arg2),
        .evt_arg3(evt_arg3), .evt_flags(evt_flags)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [NW];
    logic [1:0]  eq_kind   [EQMAX];
    logic [63:0] eq_addr   [EQMAX];
    logic [63:0] eq_data   [EQMAX];
    logic [63:0] eq_mask   [EQMAX];
    logic [7:0]  eq_master [EQMAX];
    int eq_head = 0;
    int eq_tail = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_merge(input logic [31:0] old, input logic [31:0] nw,
                                               input logic [3:0] be);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic push_exp(input logic [1:0] k, input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [3:0] m, input logic [7:0] mid);
        eq_kind[eq_tail]   = k;
        eq_addr[eq_tail]   = 64'(a);
        eq_data[eq_tail]   = 64'(d);
        eq_mask[eq_tail]   = 64'(m);
        eq_master[eq_tail] = mid;
        eq_tail++;
    endtask

    // One command cycle, entered and left at a falling edge
    task automatic access(input bit dw, input logic [AW-1:0] wa, input logic [31:0] wd,
                          input logic [3:0] wbe, input bit dr, input logic [AW-1:0] ra,
                          input logic [7:0] mid);
        logic [31:0] old = model[ra[AW-1:2]];
        wr_en = dw; wr_addr = wa; wr_data = wd; wr_be = wbe;
        rd_en = dr; rd_addr = ra; req_master = mid;
        if (dw) push_exp(2'd1, wa, wd, wbe, mid);
        if (dr) push_exp(2'd0, ra, old, 4'hF, mid);
        if (dw) model[wa[AW-1:2]] = lane_merge(model[wa[AW-1:2]], wd, wbe);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (dr) begin
            check(rd_valid === 1'b1, "R3 rd_valid after read", 64'(rd_valid), 64'd1);
            check(rd_data === old, "R9/R2/R1 read data", 64'(rd_data), 64'(old));
        end else begin
            check(rd_valid === 1'b0, "R3 rd_valid idle", 64'(rd_valid), 64'd0);
        end
        if (dw ^ dr)
            check(evt_valid === 1'b1 && evt_kind === (dw ? 2'd1 : 2'd0),
                  "R8 lone access record timing", {61'b0, evt_valid, evt_kind},
                  {61'b0, 1'b1, (dw ? 2'd1 : 2'd0)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Record monitor: compares each emitted record with the expected order
    always @(negedge clk) begin
        if (rst_n === 1'b1 && evt_valid === 1'b1) begin
            if (eq_head >= eq_tail) begin
                check(1'b0, "R5 unexpected record", 64'(evt_kind), 64'd0);
            end else begin
                check(evt_subsys === 4'd2, "R5 subsystem", 64'(evt_subsys), 64'd2);
                check(evt_kind === eq_kind[eq_head], "R5/R10 kind order", 64'(evt_kind),
                      64'(eq_kind[eq_head]));
                check(evt_arg0 === eq_addr[eq_head], "R7 arg0 address", evt_arg0, eq_addr[eq_head]);
                check(evt_arg1 === eq_data[eq_head], "R7 arg1 data", evt_arg1, eq_data[eq_head]);
                check(evt_arg2 === eq_mask[eq_head], "R7 arg2 mask", evt_arg2, eq_mask[eq_head]);
                check(evt_arg3 === {48'b0, eq_master[eq_head], 8'd2}, "R6 arg3 tag", evt_arg3,
                      {48'b0, eq_master[eq_head], 8'd2});
                check(evt_flags === 32'd0, "R6 flags", 64'(evt_flags), 64'd0);
                eq_head++;
            end
        end
    end

    // Watchdog: a hung run is reported as a failure
    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; rd_addr = '0; wr_addr = '0;
        wr_data = '0; wr_be = '0; req_master = '0;
        for (int w = 0; w < NW; w++) model[w] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rd_valid === 1'b0, "R1 reset rd_valid", 64'(rd_valid), 64'd0);
        check(evt_valid === 1'b0, "R1 reset evt_valid", 64'(evt_valid), 64'd0);
        check(rd_data === 32'd0, "R1 reset rd_data", 64'(rd_data), 64'd0);

        // R1: every word reads zero before any write
        for (int w = 0; w < NW; w++) access(1'b0, '0, '0, '0, 1'b1, AW'(w * 4 + (w % 4)), 8'(w));

        // R2, R4: every word with every lane mask, read back at another offset
        for (int w = 0; w < NW; w++) begin
            for (int m = 0; m < 16; m++) begin
                logic [31:0] d = 32'h9E37_79B9 * 32'(w * 16 + m + 1);
                access(1'b1, AW'(w * 4 + (m % 4)), d, 4'(m), 1'b0, '0, 8'(w * 16 + m));
                access(1'b0, '0, '0, '0, 1'b1, AW'(w * 4 + ((m + 1) % 4)), 8'(m));
            end
        end

        // R4: nothing leaked between words
        for (int w = 0; w < NW; w++) access(1'b0, '0, '0, '0, 1'b1, AW'(w * 4), 8'hA0);

        // R9, R8: same-word collision returns old data; write record first
        access(1'b1, AW'(20), 32'hA5A5_0F0F, 4'b1010, 1'b1, AW'(22), 8'h77);
        check(evt_valid === 1'b1 && evt_kind === 2'd1, "R8 collision write first",
              64'(evt_kind), 64'd1);
        idle(1);
        check(evt_valid === 1'b1 && evt_kind === 2'd0, "R8 collision read second",
              64'(evt_kind), 64'd0);
        idle(1);
        check(evt_valid === 1'b0, "R5 single record per access", 64'(evt_valid), 64'd0);
        access(1'b0, '0, '0, '0, 1'b1, AW'(21), 8'h11);

        // R10: two collisions back to back on different words, then drain
        access(1'b1, AW'(4), 32'h0BAD_F00D, 4'hF, 1'b1, AW'(60), 8'h21);
        access(1'b1, AW'(60), 32'h1357_9BDF, 4'b0110, 1'b1, AW'(4), 8'h22);
        idle(3);
        access(1'b0, '0, '0, '0, 1'b1, AW'(60), 8'h23);
        access(1'b0, '0, '0, '0, 1'b1, AW'(4), 8'h24);

        idle(4);
        check(eq_head == eq_tail, "R5 every access traced", 64'(eq_head), 64'(eq_tail));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule